// File: doc/BRIEF.md
# Data Hazard Forwarding and Load Interlock Control

This block steers operand forwarding and the load interlock for an in-order pipeline with five stages: fetch, decode with register read, execute, memory, and write-back. Every instruction passes through all five stages. Each cycle the block looks at the two source register numbers of the instruction in execute. It compares them with the destinations of the two older instructions that sit in the execute/memory and memory/write-back pipeline registers. From that comparison it chooses, for each ALU input, whether the operand comes from the register file or from one of those two forward paths.

It also compares the two source numbers of the instruction in decode with the destination of a load that is currently in execute. On a match it raises a hold that freezes the PC and the fetch/decode register. It also raises a flush that turns the decode/execute register into a no-op with every write enable low. This gives the dependent instruction exactly one bubble. One cycle later that instruction reaches execute, and it takes the loaded value from the memory/write-back path.

A dependence three instructions apart gets no forward path. The register file writes in the first half of a cycle and reads in the second half, so the reader in decode already sees the new value. All outputs are combinational in the current inputs. The clock and reset only time the built-in property checks. No data flows through the block, so it has no valid/ready handshake.

Top module: `hazard_ctl`

## Requirements
- R1: When `exmem_wen` is 1, `exmem_dst` is nonzero and `exmem_dst` equals an execute-stage source, that operand's select is 2'b10 (execute/memory result).
- R2: When `memwb_wen` is 1, `memwb_dst` is nonzero and equals an execute-stage source, and R1 does not apply to that operand, the select is 2'b01 (memory/write-back result).
- R3: When both older stages match the same source under R1 and R2 conditions, the select is 2'b10 (the younger producer wins).
- R4: A destination of register 0 never causes forwarding, and a load that targets register 0 never causes a stall.
- R5: In every other case the select is 2'b00 (register-file value). This covers a producer whose write enable is 0 and a producer three instructions older than the reader.
- R6: When `idex_mrd` and `idex_wen` are both 1, `idex_dst` is nonzero and equals either decode source, `hold_front` and `flush_idex` are both 1 in that cycle.
- R7: When the instruction in execute is not a load, or when its destination matches neither decode source, `hold_front` and `flush_idex` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; times the built-in property checks only |
| rst_n | input | 1 | Active-low reset; disables the property checks |
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| idex_dst | input | 5 | Destination of the instruction in execute |
| idex_wen | input | 1 | Register write enable of the instruction in execute |
| idex_mrd | input | 1 | Instruction in execute reads memory (load) |
| exmem_dst | input | 5 | Destination held in the execute/memory register |
| exmem_wen | input | 1 | Write enable held in the execute/memory register |
| memwb_dst | input | 5 | Destination held in the memory/write-back register |
| memwb_wen | input | 1 | Write enable held in the memory/write-back register |
| fwd_a | output | 2 | Select for ALU input A: 00 register file, 10 execute/memory, 01 memory/write-back |
| fwd_b | output | 2 | Select for ALU input B, same encoding |
| hold_front | output | 1 | Freeze the PC and the fetch/decode register |
| flush_idex | output | 1 | Clear the decode/execute register to a no-op |

## Verification
The interlock and the forward selects can both be active in the same cycle. A load may take its own address operand from the execute/memory path while its destination already matches the instruction waiting in decode. The bench provokes this with an ALU producer, a load that reads that producer's result, and an immediate user of the load, all issued back to back. A behavioural pipeline model in the bench then expects a 2'b10 select and an active stall in the same cycle, followed by a 2'b01 select for the user after its single bubble.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MWB = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    exm_dst,
  input  logic             exm_wen,
  input  logic [AW-1:0]    mwb_dst,
  input  logic             mwb_wen,
  output hz_pkg::fwd_sel_e sel
);
  logic hit_exm, hit_mwb;

  // a producer counts only if it writes a real (nonzero) register
  assign hit_exm = exm_wen && (exm_dst != '0) && (exm_dst == src);
  assign hit_mwb = mwb_wen && (mwb_dst != '0) && (mwb_dst == src);

  // nearest producer first
  always_comb begin
    if (hit_exm)      sel = hz_pkg::FWD_EXM;
    else if (hit_mwb) sel = hz_pkg::FWD_MWB;
    else              sel = hz_pkg::FWD_RF;
  end
endmodule

// File: rtl/luse_detect.sv
module luse_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             ld_dst,
  input  logic                      ld_wen,
  input  logic                      ld_mrd,
  input  logic [NSRC-1:0][AW-1:0]   dec_src,
  output logic                      hazard
);
  logic [NSRC-1:0] hits;
  logic            real_load;

  assign real_load = ld_mrd && ld_wen && (ld_dst != '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hits[i] = real_load && (dec_src[i] == ld_dst);
  end

  assign hazard = |hits;

  assert_nonload_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mrd |-> !hazard);
  assert_zero_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dst == '0) |-> !hazard);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] idex_dst,
  input  logic          idex_wen,
  input  logic          idex_mrd,
  input  logic [AW-1:0] exmem_dst,
  input  logic          exmem_wen,
  input  logic [AW-1:0] memwb_dst,
  input  logic          memwb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          hold_front,
  output logic          flush_idex
);
  logic [NSRC-1:0][AW-1:0] ex_src, id_src;
  hz_pkg::fwd_sel_e        sel_arr [NSRC];
  logic                    lu_hazard;

  assign ex_src = {ex_src_b, ex_src_a};
  assign id_src = {id_src_b, id_src_a};

  for (genvar i = 0; i < NSRC; i++) begin : g_op
    fwd_pick #(.AW(AW)) u_pick (
      .src     (ex_src[i]),
      .exm_dst (exmem_dst),
      .exm_wen (exmem_wen),
      .mwb_dst (memwb_dst),
      .mwb_wen (memwb_wen),
      .sel     (sel_arr[i])
    );
  end

  luse_detect #(.AW(AW), .NSRC(NSRC)) u_luse (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_dst  (idex_dst),
    .ld_wen  (idex_wen),
    .ld_mrd  (idex_mrd),
    .dec_src (id_src),
    .hazard  (lu_hazard)
  );

  assign fwd_a      = sel_arr[0];
  assign fwd_b      = sel_arr[1];
  assign hold_front = lu_hazard;
  assign flush_idex = lu_hazard;

  assert_exm_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_wen && exmem_dst != '0 && exmem_dst == ex_src_a) |-> fwd_a == 2'b10);
  assert_mwb_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (memwb_wen && memwb_dst != '0 && memwb_dst == ex_src_b &&
     !(exmem_wen && exmem_dst == ex_src_b)) |-> fwd_b == 2'b01);
  assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_wen && memwb_wen && exmem_dst != '0 && exmem_dst == memwb_dst &&
     memwb_dst == ex_src_b) |-> fwd_b == 2'b10);
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> fwd_a == 2'b00);
  assert_no_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exmem_wen && !memwb_wen) |-> (fwd_a == 2'b00 && fwd_b == 2'b00));
  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_mrd && idex_wen && idex_dst != '0 &&
     (idex_dst == id_src_a || idex_dst == id_src_b)) |-> (hold_front && flush_idex));
endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  typedef struct packed {
    logic [4:0] d, s1, s2;
    logic       we, ld;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ex_src_a, ex_src_b, id_src_a, id_src_b, idex_dst, exmem_dst, memwb_dst;
  logic idex_wen, idex_mrd, exmem_wen, memwb_wen;
  logic [1:0] fwd_a, fwd_b;
  logic hold_front, flush_idex;

  int vectors = 0, errors = 0;
  ins_t prog[$];
  ins_t s_id = NOP, s_ex = NOP, s_mem = NOP, s_wb = NOP;
  logic was_stall = 1'b0;

  always #2 clk = ~clk;

  hazard_ctl u0 (.*);

  function automatic ins_t mk(input int d, input int a, input int b, input bit we, input bit ld);
    ins_t t;
    t.d = 5'(d); t.s1 = 5'(a); t.s2 = 5'(b); t.we = we; t.ld = ld;
    return t;
  endfunction

  function automatic bit writes(input ins_t t, input logic [4:0] r);
    return t.we && t.d != 0 && t.d == r;
  endfunction

  // nearest older writer wins; otherwise register file
  function automatic logic [1:0] exp_sel(input logic [4:0] r);
    if (writes(s_mem, r)) return 2'b10;
    if (writes(s_wb, r))  return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(input logic [4:0] r, input logic [1:0] e);
    if (e == 2'b10 && writes(s_wb, r)) return "R3";
    if (e == 2'b10) return "R1";
    if (e == 2'b01) return "R2";
    if (r == 0)     return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive();
    ex_src_a = s_ex.s1;  ex_src_b = s_ex.s2;
    id_src_a = s_id.s1;  id_src_b = s_id.s2;
    idex_dst = s_ex.d;   idex_wen = s_ex.we;  idex_mrd = s_ex.ld;
    exmem_dst = s_mem.d; exmem_wen = s_mem.we;
    memwb_dst = s_wb.d;  memwb_wen = s_wb.we;
  endtask

  task automatic compare();
    logic [1:0] ea, eb;
    logic es;
    string st;
    ea = exp_sel(s_ex.s1);
    eb = exp_sel(s_ex.s2);
    es = s_ex.ld && s_ex.we && s_ex.d != 0 && (s_ex.d == s_id.s1 || s_ex.d == s_id.s2);
    chk(sel_tag(s_ex.s1, ea), "fwd_a", fwd_a, ea);
    chk(sel_tag(s_ex.s2, eb), "fwd_b", fwd_b, eb);
    st = es ? "R6" : ((s_ex.ld && s_ex.d == 0) ? "R4" : "R7");
    chk(st, "hold/flush", {hold_front, flush_idex}, {es, es});
    was_stall = es;
  endtask

  initial begin
    // distances 1, 2, 3 from an ALU producer of r1
    prog.push_back(mk(1, 2, 3, 1, 0));
    prog.push_back(mk(4, 1, 5, 1, 0));   // R1 on a
    prog.push_back(mk(6, 7, 1, 1, 0));   // R2 on b
    prog.push_back(mk(8, 1, 1, 1, 0));   // distance 3: R5
    // two producers of r9, then a reader: R3
    prog.push_back(mk(9, 2, 2, 1, 0));
    prog.push_back(mk(9, 3, 3, 1, 0));
    prog.push_back(mk(10, 9, 9, 1, 0));
    // writer of r0, then readers of r0: R4
    prog.push_back(mk(0, 2, 3, 1, 0));
    prog.push_back(mk(11, 0, 0, 1, 0));
    // write enable low with a matching destination: R5
    prog.push_back(mk(12, 2, 3, 0, 0));
    prog.push_back(mk(13, 12, 12, 1, 0));
    // load-use on a: R6 then one bubble, then forwarding
    prog.push_back(mk(14, 2, 0, 1, 1));
    prog.push_back(mk(15, 14, 3, 1, 0));
    // load, unrelated slot instruction, later user: R7
    prog.push_back(mk(16, 2, 0, 1, 1));
    prog.push_back(mk(17, 2, 3, 1, 0));
    prog.push_back(mk(18, 3, 16, 1, 0));
    // load to r0 followed by reader of r0: R4
    prog.push_back(mk(0, 2, 0, 1, 1));
    prog.push_back(mk(19, 0, 0, 1, 0));
    // ALU producer read in decode by next: no stall R7
    prog.push_back(mk(20, 2, 3, 1, 0));
    prog.push_back(mk(21, 20, 20, 1, 0));
    // forward into a load while that load stalls its user (same cycle)
    prog.push_back(mk(22, 2, 3, 1, 0));
    prog.push_back(mk(23, 22, 0, 1, 1));
    prog.push_back(mk(24, 5, 23, 1, 0));

    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", "reset fwd_a", fwd_a, 2'b00);
    chk("R5", "reset fwd_b", fwd_b, 2'b00);
    chk("R7", "reset hold/flush", {hold_front, flush_idex}, 2'b00);
    rst_n = 1'b1;

    while (prog.size() > 0 || s_id != NOP || s_ex != NOP || s_mem != NOP || s_wb != NOP) begin
      @(posedge clk);
      #1;
      s_wb = s_mem;
      s_mem = s_ex;
      if (was_stall) s_ex = NOP;
      else begin
        s_ex = s_id;
        s_id = (prog.size() > 0) ? prog.pop_front() : NOP;
      end
      drive();
      @(negedge clk);
      compare();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule